// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between the program-fetch address of an 8-bit microcontroller core and a program memory of up to 128K bytes. The core issues 16-bit code addresses. The mapper turns each one into a 17-bit physical address. The lower 32K of code space always shows one fixed common bank. The upper 32K is a window onto one of three switchable banks, and a two-bit special function register chooses which one.

Software changes the bank by writing the bank register through a byte-wide SFR port. The same port reads the register back. A build parameter selects a flat 64K variant. In that variant there is no bank switching: the logical address passes straight through, writes to the register are ignored, and the register reads as zero.

The physical memory is divided into four 32K slots, and each slot's number forms physical address bits 16:15. The common bank occupies slot 0. Switchable bank k occupies slot k+1.

Top module: `prog_bank_mapper`

## Requirements
- R1: When logical address bit 15 is 0, the physical address is {2'b00, logical[14:0]}, whatever the bank register holds.
- R2: When logical address bit 15 is 1 and the bank register holds k (0, 1 or 2), the physical address is {k+1 as 2 bits, logical[14:0]}.
- R3: A write with sfrWrEn=1 and sfrAddr equal to BANK_SFR_ADDR (default 8'hD7) loads sfrWrData[1:0] into the bank register on that clock edge. A fetch presented in the same cycle as the write still uses the old value. Data bits 7:2 are discarded.
- R4: A bank register value of 3 is reserved. An upper-half fetch then maps like bank 2 (slot 3), and bankInvalid is 1 for as long as the register holds 3. For any other value bankInvalid is 0.
- R5: Reset (rstN=0) clears the bank register to 0.
- R6: The read path works as follows. With sfrRdEn=1 and sfrAddr=BANK_SFR_ADDR, sfrRdData is {6'b0, bank}. In every other case sfrRdData is 8'h00.
- R7: Writes to any other SFR address leave the bank register unchanged.
- R8: physValid equals fetchStrobe in the same cycle.
- R9: With FLAT_64K=1 the following hold:
  - physAddr is {1'b0, fetchAddr}.
  - Bank-register writes are ignored.
  - sfrRdData is always 8'h00.
  - bankInvalid is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchAddr | input | 16 | Logical program-fetch address |
| fetchStrobe | input | 1 | Fetch request qualifier |
| sfrAddr | input | 8 | SFR access address |
| sfrWrEn | input | 1 | SFR write enable |
| sfrWrData | input | 8 | SFR write data |
| sfrRdEn | input | 1 | SFR read enable |
| sfrRdData | output | 8 | SFR read data |
| physAddr | output | 17 | Physical program memory address |
| physValid | output | 1 | Physical address qualifier |
| bankInvalid | output | 1 | Reserved bank value is selected |

## Verification
The bench builds two copies of the block. The first uses the default banked configuration (FLAT_64K=0). It exercises the following behaviour:
- every bank value, including the reserved value 3;
- both halves of the code space;
- writes that carry junk in the high data bits;
- writes to a foreign SFR address;
- a fetch issued in the same cycle as a bank write.

The second copy uses FLAT_64K=1. It confirms pass-through addressing, ignored writes and the zero read-back.

// File: rtl/prog_bank_pkg.sv
package prog_bank_pkg;
  parameter int LOGIC_ADDR_W = 16;
  parameter int PHYS_ADDR_W  = 17;
  parameter int SFR_W        = 8;
  parameter int BANK_SEL_W   = 2;

  typedef struct packed {
    logic bankWrite;
    logic bankRead;
  } bank_strobe_t;
endpackage

// File: rtl/prog_bank_ctrl.sv
module prog_bank_ctrl
  import prog_bank_pkg::*;
#(
  parameter int               SFR_AW        = SFR_W,
  parameter logic [SFR_AW-1:0] BANK_SFR_ADDR = 8'hD7,
  parameter bit               FLAT_64K      = 1'b0
) (
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              sfrRdEn,
  output bank_strobe_t      strobe
);
  logic addrHit;

  always_comb begin
    addrHit         = (sfrAddr == BANK_SFR_ADDR);
    strobe.bankRead = sfrRdEn && addrHit;
    // In the flat build the register is frozen, so no write strobe is issued.
    strobe.bankWrite = !FLAT_64K && sfrWrEn && addrHit;
  end
endmodule

// File: rtl/prog_bank_datapath.sv
module prog_bank_datapath
  import prog_bank_pkg::*;
#(
  parameter int LA_W     = LOGIC_ADDR_W,
  parameter int PA_W     = PHYS_ADDR_W,
  parameter int DW       = SFR_W,
  parameter int SEL_W    = BANK_SEL_W,
  parameter bit FLAT_64K = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  bank_strobe_t    strobe,
  input  logic [DW-1:0]   wrData,
  input  logic [LA_W-1:0] fetchAddr,
  output logic [DW-1:0]   rdData,
  output logic [PA_W-1:0] physAddr,
  output logic            invalid,
  output logic [SEL_W-1:0] curBank
);
  localparam int OFS_W = LA_W - 1;
  localparam logic [SEL_W-1:0] RESERVED = '1;
  localparam logic [SEL_W-1:0] LAST_OK  = RESERVED - 1'b1;

  generate
    if (FLAT_64K) begin : g_flat
      logic unusedFlat;
      assign unusedFlat = ^{clk, rstN, strobe, wrData};
      assign curBank    = '0;
      assign rdData     = '0;
      assign invalid    = 1'b0;
      assign physAddr   = {{(PA_W-LA_W){1'b0}}, fetchAddr};
    end else begin : g_banked
      logic [SEL_W-1:0] bankReg;
      logic [SEL_W-1:0] effBank;
      logic [SEL_W-1:0] slot;
      logic             unusedHigh;

      assign unusedHigh = ^wrData[DW-1:SEL_W];

      always_ff @(posedge clk) begin
        if (!rstN)
          bankReg <= '0;
        else if (strobe.bankWrite)
          bankReg <= wrData[SEL_W-1:0];
      end

      always_comb begin
        // The reserved code aliases onto the highest legal bank.
        effBank = (bankReg == RESERVED) ? LAST_OK : bankReg;
        slot    = fetchAddr[LA_W-1] ? effBank + 1'b1 : '0;
      end

      assign physAddr = {slot, fetchAddr[OFS_W-1:0]};
      assign invalid  = (bankReg == RESERVED);
      assign rdData   = strobe.bankRead ? {{(DW-SEL_W){1'b0}}, bankReg} : '0;
      assign curBank  = bankReg;
    end
  endgenerate
endmodule

// File: rtl/prog_bank_mapper.sv
module prog_bank_mapper
  import prog_bank_pkg::*;
#(
  parameter int         LA_W          = LOGIC_ADDR_W,
  parameter int         PA_W          = PHYS_ADDR_W,
  parameter int         DW            = SFR_W,
  parameter int         SEL_W         = BANK_SEL_W,
  parameter logic [7:0] BANK_SFR_ADDR = 8'hD7,
  parameter bit         FLAT_64K      = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LA_W-1:0] fetchAddr,
  input  logic            fetchStrobe,
  input  logic [7:0]      sfrAddr,
  input  logic            sfrWrEn,
  input  logic [DW-1:0]   sfrWrData,
  input  logic            sfrRdEn,
  output logic [DW-1:0]   sfrRdData,
  output logic [PA_W-1:0] physAddr,
  output logic            physValid,
  output logic            bankInvalid
);
  bank_strobe_t     strobe;
  logic [SEL_W-1:0] curBank;

  prog_bank_ctrl #(
    .SFR_AW(8), .BANK_SFR_ADDR(BANK_SFR_ADDR), .FLAT_64K(FLAT_64K)
  ) u_ctrl (
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrRdEn(sfrRdEn), .strobe(strobe)
  );

  prog_bank_datapath #(
    .LA_W(LA_W), .PA_W(PA_W), .DW(DW), .SEL_W(SEL_W), .FLAT_64K(FLAT_64K)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(sfrWrData),
    .fetchAddr(fetchAddr), .rdData(sfrRdData), .physAddr(physAddr),
    .invalid(bankInvalid), .curBank(curBank)
  );

  assign physValid = fetchStrobe;
endmodule

// File: rtl/prog_bank_mapper_checker.sv
module prog_bank_mapper_checker #(
  parameter logic [7:0] BANK_SFR_ADDR = 8'hD7,
  parameter bit         FLAT_64K      = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] fetchAddr,
  input logic        fetchStrobe,
  input logic [7:0]  sfrAddr,
  input logic        sfrWrEn,
  input logic        sfrRdEn,
  input logic [7:0]  sfrRdData,
  input logic [16:0] physAddr,
  input logic        physValid,
  input logic        bankInvalid,
  input logic [1:0]  curBank
);
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> physAddr[14:0] == fetchAddr[14:0]); // R2

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    physValid == fetchStrobe); // R8

  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    sfrRdData[7:2] == 6'b0); // R6

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !sfrRdEn |-> sfrRdData == 8'h00); // R6

  AST_FOREIGN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(sfrWrEn && sfrAddr == BANK_SFR_ADDR) |=> $stable(curBank)); // R7

  generate
    if (FLAT_64K) begin : g_flat_chk
      AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rstN)
        physAddr == {1'b0, fetchAddr}); // R9
      AST_FLAT_NO_INVALID: assert property (@(posedge clk) disable iff (!rstN)
        !bankInvalid); // R9
    end else begin : g_bank_chk
      AST_LOWER_COMMON: assert property (@(posedge clk) disable iff (!rstN)
        !fetchAddr[15] |-> physAddr[16:15] == 2'b00); // R1
      AST_RESERVED_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
        (bankInvalid && fetchAddr[15]) |-> physAddr[16:15] == 2'b11); // R4
      AST_UPPER_NOT_COMMON: assert property (@(posedge clk) disable iff (!rstN)
        fetchAddr[15] |-> physAddr[16:15] != 2'b00); // R2
    end
  endgenerate
endmodule

bind prog_bank_mapper prog_bank_mapper_checker #(
  .BANK_SFR_ADDR(BANK_SFR_ADDR), .FLAT_64K(FLAT_64K)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .fetchStrobe(fetchStrobe),
  .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrRdEn(sfrRdEn), .sfrRdData(sfrRdData),
  .physAddr(physAddr), .physValid(physValid), .bankInvalid(bankInvalid),
  .curBank(curBank)
);

// File: tb/prog_bank_mapper_bench.sv
module prog_bank_mapper_bench;
  localparam logic [7:0] BANK = 8'hD7;
  localparam int NVEC = 9;
  // {write, wrData, fetchAddr, expected physAddr, expected bankInvalid}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 8'h01, 16'h8000, 17'h10000, 1'b0},
    {1'b0, 8'h00, 16'hFFFF, 17'h17FFF, 1'b0},
    {1'b0, 8'h00, 16'h7FFF, 17'h07FFF, 1'b0},
    {1'b1, 8'h02, 16'h9ABC, 17'h19ABC, 1'b0},
    {1'b1, 8'h03, 16'hC000, 17'h1C000, 1'b1},
    {1'b0, 8'h00, 16'h0000, 17'h00000, 1'b1},
    {1'b1, 8'hFC, 16'hA5A5, 17'h0A5A5, 1'b0},
    {1'b1, 8'h05, 16'h8001, 17'h10001, 1'b0},
    {1'b1, 8'h02, 16'h1234, 17'h01234, 1'b0}
  };

  logic clk = 0, rstN = 0;
  logic [15:0] fetchAddr = '0;
  logic fetchStrobe = 0, sfrWrEn = 0, sfrRdEn = 0;
  logic [7:0] sfrAddr = '0, sfrWrData = '0;
  logic [7:0] rdB, rdF;
  logic [16:0] paB, paF;
  logic pvB, pvF, invB, invF;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prog_bank_mapper u_prog_bank_mapper (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .fetchStrobe(fetchStrobe),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdEn(sfrRdEn),
    .sfrRdData(rdB), .physAddr(paB), .physValid(pvB), .bankInvalid(invB));

  prog_bank_mapper #(.FLAT_64K(1'b1)) u_prog_bank_mapper_flat (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .fetchStrobe(fetchStrobe),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdEn(sfrRdEn),
    .sfrRdData(rdF), .physAddr(paF), .physValid(pvF), .bankInvalid(invF));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrBank(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1; sfrRdEn = 0;
    @(posedge clk);
    @(negedge clk);
    sfrWrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] expBank;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R5 reset state, R6 readback
    sfrAddr = BANK; sfrRdEn = 1; fetchAddr = 16'hC123; fetchStrobe = 1; #1;
    chk("R5 reset bank read", 32'(rdB), 32'h00);
    chk("R5 reset upper maps bank0", 32'(paB), 32'h0C123);
    chk("R8 physValid high", 32'(pvB), 32'h1);
    chk("R4 no invalid after reset", 32'(invB), 32'h0);
    expBank = 2'd0;

    // Vector table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][42]) begin
        wrBank(BANK, VEC[i][41:34]);
        expBank = VEC[i][35:34];
      end
      @(negedge clk);
      fetchAddr = VEC[i][33:18]; fetchStrobe = 1; sfrAddr = BANK; sfrRdEn = 1; #1;
      chk(VEC[i][33] ? "R2 upper map" : "R1 lower map", 32'(paB), 32'(VEC[i][17:1]));
      chk("R4 invalid flag", 32'(invB), 32'(VEC[i][0]));
      chk("R6 R3 readback", 32'(rdB), {30'd0, expBank});
    end

    // R3 same-cycle write uses old bank (bank currently 2)
    @(negedge clk);
    sfrAddr = BANK; sfrWrData = 8'h01; sfrWrEn = 1; fetchAddr = 16'h8010; #1;
    chk("R3 same-cycle old bank", 32'(paB), 32'h18010);
    @(posedge clk); @(negedge clk); sfrWrEn = 0; #1;
    chk("R3 new bank after edge", 32'(paB), 32'h10010);

    // R7 foreign address write ignored
    wrBank(8'hD6, 8'h03);
    @(negedge clk); sfrAddr = BANK; sfrRdEn = 1; fetchAddr = 16'hF000; #1;
    chk("R7 foreign write no change", 32'(paB), 32'h17000);
    chk("R7 foreign write read", 32'(rdB), 32'h01);

    // R6 read disabled or wrong address gives zero
    sfrRdEn = 0; #1;
    chk("R6 read disabled zero", 32'(rdB), 32'h00);
    sfrRdEn = 1; sfrAddr = 8'h00; #1;
    chk("R6 other address zero", 32'(rdB), 32'h00);

    // R8 strobe low
    fetchStrobe = 0; #1;
    chk("R8 physValid low", 32'(pvB), 32'h0);

    // R9 flat build: write attempt was made several times above
    sfrAddr = BANK; sfrRdEn = 1; fetchAddr = 16'hC000; #1;
    chk("R9 flat passthrough", 32'(paF), 32'h0C000);
    chk("R9 flat read zero", 32'(rdF), 32'h00);
    chk("R9 flat no invalid", 32'(invF), 32'h0);
    wrBank(BANK, 8'h03);
    @(negedge clk); fetchAddr = 16'hFFFF; sfrAddr = BANK; sfrRdEn = 1; #1;
    chk("R9 flat top address", 32'(paF), 32'h0FFFF);
    chk("R9 flat write ignored", 32'(rdF), 32'h00);
    chk("R4 banked invalid on 3", 32'(invB), 32'h1);
    chk("R4 reserved alias", 32'(paB), 32'h1FFFF);

    // R5 reset clears bank
    @(negedge clk); rstN = 0;
    @(posedge clk); @(negedge clk); rstN = 1; sfrRdEn = 1; sfrAddr = BANK; #1;
    chk("R5 reset clears bank", 32'(rdB), 32'h00);
    chk("R5 reset clears invalid", 32'(invB), 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule